// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Set/Clear Register Writes

This block holds the configuration and output state for 32 general-purpose pins. The pins form two banks of sixteen. Each bank has eight 16-bit control registers: output level, output enable, input enable, open-drain, pull-up, pull-down, input inversion and output inversion. A single 32-bit word updates any register. Its low half names the bits to set and its high half names the same bits to clear. Software can therefore change one pin without first reading the register.

The controller sits on a simple single-cycle register bus. It drives per-pin output level, output enable, open-drain and pull controls toward the pads. It also returns a conditioned copy of the pad inputs. Pad electrical behaviour and interrupts are handled elsewhere.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every register bit is 0, so pin_drive, pin_oe, pin_od, pin_pu, pin_pd and pin_sample are all 0, and every register reads as 0.
- R2: A write with bus_we=1 sets register bit n wherever bus_wdata bit n (n = 0..15) is 1. The effect is visible on the outputs from the next cycle.
- R3: A write clears register bit n wherever bus_wdata bit n+16 is 1. Bits with neither their set bit nor their clear bit at 1 keep their value.
- R4: When the set bit and the clear bit of the same pin are both 1 in one write, the register bit ends at 0.
- R5: bus_addr[3] selects the bank: 0 for pins 0..15 and 1 for pins 16..31. Pin p uses register bit p mod 16. A write to one bank leaves the other bank unchanged.
- R6: bus_addr[2:0] selects the register: 0 output level, 1 output enable, 2 input enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input invert, 7 output invert. bus_rdata returns the addressed register's 16 bits in its low half, with the high half 0.
- R7: pin_drive equals the output level XOR the output-invert bit, per pin.
- R8: pin_sample equals pad_in XOR the input-invert bit, ANDed with the input-enable bit, per pin.
- R9: pin_oe equals the output-enable bit, except that for an open-drain pin it is 1 only while pin_drive is 0.
- R10: pin_od, pin_pu and pin_pd show the open-drain, pull-up and pull-down register bits directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Bank (bit 3) and register (bits 2:0) select |
| bus_wdata | input | 32 | Set mask in bits 15:0, clear mask in bits 31:16 |
| bus_rdata | output | 32 | Addressed register contents, combinational |
| pad_in | input | 32 | Raw pad input levels |
| pin_sample | output | 32 | Conditioned input levels |
| pin_drive | output | 32 | Output level toward the pads |
| pin_oe | output | 32 | Output enable toward the pads |
| pin_od | output | 32 | Open-drain select per pin |
| pin_pu | output | 32 | Pull-up enable per pin |
| pin_pd | output | 32 | Pull-down enable per pin |

## Verification
The set/clear update is tested with four kinds of write word. A word with only set bits shows that set works alone. A word with only clear bits shows that untouched bits keep their value. A word with set and clear overlapping on some pins confirms that clear wins. A word aimed at the high bank confirms that the address offset and the mod-16 bit index land on pins 16..31 and leave the low bank alone. Further sequences enable inversion, input gating and open-drain over a known output pattern, so that each derived pad signal is told apart from the raw register it depends on.

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank #(
  parameter int BANK_W    = 16,
  parameter int NUM_BANKS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [3:0]                   bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [BANK_W*NUM_BANKS-1:0]  pad_in,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_sample,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_drive,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_oe,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_od,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_pu,
  output logic [BANK_W*NUM_BANKS-1:0]  pin_pd
);
  localparam int PINS     = BANK_W * NUM_BANKS;
  localparam int NUM_FEAT = 8;
  localparam int FEAT_AW  = $clog2(NUM_FEAT);
  localparam int ADDR_W   = 4;

  localparam int F_LVL  = 0;
  localparam int F_OE   = 1;
  localparam int F_IEN  = 2;
  localparam int F_OD   = 3;
  localparam int F_PU   = 4;
  localparam int F_PD   = 5;
  localparam int F_IINV = 6;
  localparam int F_OINV = 7;

  logic [PINS-1:0] feat [NUM_FEAT];

  wire [BANK_W-1:0] set_mask = bus_wdata[BANK_W-1:0];
  wire [BANK_W-1:0] clr_mask = bus_wdata[2*BANK_W-1:BANK_W];

  for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      wire hit = bus_we && (bus_addr == ADDR_W'(b * NUM_FEAT + f));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          feat[f][b*BANK_W +: BANK_W] <= '0;
        else if (hit)
          feat[f][b*BANK_W +: BANK_W] <= (feat[f][b*BANK_W +: BANK_W] | set_mask) & ~clr_mask;
      end
    end
  end

  wire [FEAT_AW-1:0]        sel_feat = bus_addr[FEAT_AW-1:0];
  wire [ADDR_W-FEAT_AW-1:0] sel_bank = bus_addr[ADDR_W-1:FEAT_AW];
  wire [PINS-1:0]           sel_reg  = feat[sel_feat];

  always_comb begin
    bus_rdata = '0;
    if (int'(sel_bank) < NUM_BANKS)
      bus_rdata[BANK_W-1:0] = sel_reg[int'(sel_bank)*BANK_W +: BANK_W];
  end

  assign pin_drive  = feat[F_LVL] ^ feat[F_OINV];
  assign pin_oe     = feat[F_OE] & ~(feat[F_OD] & pin_drive);
  assign pin_sample = (pad_in ^ feat[F_IINV]) & feat[F_IEN];
  assign pin_od     = feat[F_OD];
  assign pin_pu     = feat[F_PU];
  assign pin_pd     = feat[F_PD];
endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk #(
  parameter int BANK_W = 16,
  parameter int PINS   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [3:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [PINS-1:0] pin_sample,
  input logic [PINS-1:0] pin_drive,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] pin_od,
  input logic [PINS-1:0] pin_pu,
  input logic [PINS-1:0] pin_pd
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pin_drive == '0 && pin_oe == '0 && pin_od == '0 &&
                pin_pu == '0 && pin_pd == '0 && pin_sample == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd4) |=>
      ((pin_pu[BANK_W-1:0] & $past(bus_wdata[BANK_W-1:0] & ~bus_wdata[2*BANK_W-1:BANK_W]))
        == $past(bus_wdata[BANK_W-1:0] & ~bus_wdata[2*BANK_W-1:BANK_W])));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'd4) |=>
      ((pin_pu[BANK_W-1:0] & $past(bus_wdata[2*BANK_W-1:BANK_W])) == '0));

  p_bank_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[3]) |=> $stable(pin_pu[PINS-1:BANK_W]));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_pu) && $stable(pin_pd) && $stable(pin_od)));

  p_open_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & pin_drive & pin_oe) == '0));
endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.BANK_W(BANK_W), .PINS(BANK_W*NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_sample(pin_sample), .pin_drive(pin_drive),
  .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd)
);

// File: tb/gpio_setclr_bank_test.sv
module gpio_setclr_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pin_sample, pin_drive, pin_oe, pin_od, pin_pu, pin_pd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pin_sample(pin_sample), .pin_drive(pin_drive), .pin_oe(pin_oe),
    .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    #1;
    check("R1 drive", pin_drive, 32'h0);
    check("R1 oe", pin_oe, 32'h0);
    check("R1 pulls", pin_pu | pin_pd | pin_od, 32'h0);
    check("R1 sample", pin_sample, 32'h0);
    for (int a = 0; a < 16; a++) rd_check("R1 read", 4'(a), 32'h0);
  endtask

  task automatic t_set_clear;
    wr(4'd0, 32'h0000_00A5);
    check("R2 set", pin_drive, 32'h0000_00A5);
    rd_check("R6 read level", 4'd0, 32'h0000_00A5);
    wr(4'd0, 32'h0005_0000);
    check("R3 clear", pin_drive, 32'h0000_00A0);
    wr(4'd0, 32'h00F0_00F3);
    check("R4 clear wins", pin_drive, 32'h0000_0003);
  endtask

  task automatic t_high_bank;
    wr(4'd8, 32'h0000_8001);
    check("R5 high bank", pin_drive, 32'h8001_0003);
    rd_check("R6 read high", 4'd8, 32'h0000_8001);
    rd_check("R5 low kept", 4'd0, 32'h0000_0003);
  endtask

  task automatic t_invert_out;
    wr(4'd15, 32'h0000_FFFF);
    check("R7 out invert", pin_drive, 32'h7FFE_0003);
    wr(4'd15, 32'hFFFF_0000);
    check("R7 invert off", pin_drive, 32'h8001_0003);
  endtask

  task automatic t_input;
    pad_in = 32'h1234_5678;
    #1;
    check("R8 gated off", pin_sample, 32'h0);
    wr(4'd2, 32'h0000_00FF);
    wr(4'd6, 32'h0000_000F);
    check("R8 sample", pin_sample, 32'h0000_0077);
  endtask

  task automatic t_open_drain;
    wr(4'd1, 32'h0000_FFFF);
    check("R9 plain oe", pin_oe, 32'h0000_FFFF);
    wr(4'd3, 32'h0000_000F);
    check("R9 od oe", pin_oe, 32'h0000_FFFC);
    wr(4'd0, 32'h0003_0000);
    check("R9 od low drives", pin_oe, 32'h0000_FFFF);
  endtask

  task automatic t_pulls;
    wr(4'd4, 32'h0000_1111);
    wr(4'd13, 32'h0000_0022);
    check("R10 pu", pin_pu, 32'h0000_1111);
    check("R10 pd", pin_pd, 32'h0022_0000);
    check("R10 od", pin_od, 32'h0000_000F);
    rd_check("R6 read pd high", 4'd13, 32'h0000_0022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_set_clear();
    t_high_bank();
    t_invert_out();
    t_input();
    t_open_drain();
    t_pulls();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule